// File: doc/BRIEF.md
# I2C Master Byte-Command Engine

This block is an I2C bus master that performs exactly one bus phase per software command. Software places a byte on the data input, picks an operation code and pulses the trigger. Four codes are recognised: start (also used as repeated start), byte send, ACK/NAK check and stop. Each phase reports completion by dropping the busy flag, writing a phase-specific status code and pulsing the interrupt line for one cycle. Software therefore chains the phases of a transaction itself: for a 7-bit target it sends a start, then the address byte (address in bits 7..1, direction in bit 0, where 0 means master writes and 1 means master reads), then an ACK check, then data bytes with their checks, then a stop.

A 10-bit target uses the same byte-send command for every byte. The first byte is 1,1,1,1,0,A9,A8,direction and the second byte carries A7..A0. To read from such a target, software sends both bytes with direction 0, issues a repeated start, and then sends the first byte again with direction 1.

SCL and SDA are open drain. The block only reports whether it pulls each line low, and it reads SDA back. Bus timing is set by a divider input. Each SCL period is split into four quarters, and each quarter lasts divider+1 system clocks.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset, busy, status (0x0) and the interrupt are all 0, and neither SCL nor SDA is pulled low.
- R2: A trigger is taken only with code 0x1 (start), 0x2 (send), 0x4 (stop) or 0x6 (ACK check). Busy is 1 in the cycle after the trigger edge. A trigger with any other code leaves busy and status unchanged.
- R3: For code 0x2, if no byte is still shifting, busy returns to 0 two clocks after the trigger edge and status becomes 0x2. The captured byte is then sent MSB first, one bit per SCL high pulse, with eight pulses in total.
- R4: For code 0x6, the master releases SDA for one SCL clock and samples it while SCL is high. Busy stays 1 until that clock ends. Status becomes 0x5 if SDA was low (ACK) and 0x6 if it was high (NAK).
- R5: Code 0x1 produces exactly one SDA fall while SCL is high and ends with status 0x1 and SCL held low. It works from the idle bus and as a repeated start after a byte.
- R6: Code 0x4 produces exactly one SDA rise while SCL is high. It ends with status 0x4 and with both lines released.
- R7: During byte sends and ACK checks, SDA changes only while SCL is low. Over any sequence of operations, the number of start and stop conditions seen on the bus equals the number of start and stop commands issued.
- R8: Every SCL high pulse of a byte or ACK clock lasts 2*(divider+1) system clocks.
- R9: A trigger made while busy is 1 is ignored: the running operation, its status and the bus are unaffected.
- R10: A trigger accepted while an earlier byte is still shifting (busy 0) waits. It runs after the last bit of that byte, and busy stays 1 until it completes.
- R11: The interrupt is high for exactly one cycle, in the first cycle that busy reads 0 after being 1, and at no other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_div_i | input | DIV_W | Quarter-period length minus one, in system clocks |
| tx_byte_i | input | 8 | Byte captured at an accepted trigger |
| op_i | input | 3 | Operation code: 0x1 start, 0x2 send, 0x4 stop, 0x6 ACK check |
| trig_i | input | 1 | Command strobe, sampled on the rising clock edge |
| busy_o | output | 1 | Command accepted and not yet finished |
| status_o | output | 3 | Result of the last finished phase: 0x1, 0x2, 0x4, 0x5 or 0x6 |
| irq_o | output | 1 | One-cycle strobe when busy falls |
| scl_pull_o | output | 1 | 1 pulls SCL low; 0 releases it |
| sda_i | input | 1 | Sensed level of the SDA line |
| sda_pull_o | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
Busy is 1 one clock after the trigger edge. For a send on an idle shifter, busy is 0 one clock later, with status 0x2 and the interrupt high, so the bench samples at these two falling clock edges exactly. Start, stop and ACK checks last a number of clocks that depends on the divider. For those, the bench polls busy at falling clock edges and reads status and the interrupt on the first edge where busy is 0, which is the only cycle the strobe is valid. Bus-level results are collected by an edge monitor on the resolved lines and compared once the operation has finished: captured bits, start and stop counts, and SCL high width against 2*(divider+1) clock periods.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

    localparam logic [2:0] OP_START = 3'h1;
    localparam logic [2:0] OP_SEND  = 3'h2;
    localparam logic [2:0] OP_STOP  = 3'h4;
    localparam logic [2:0] OP_ACK   = 3'h6;

    localparam logic [2:0] ST_NONE  = 3'h0;
    localparam logic [2:0] ST_START = 3'h1;
    localparam logic [2:0] ST_SENT  = 3'h2;
    localparam logic [2:0] ST_STOP  = 3'h4;
    localparam logic [2:0] ST_ACK   = 3'h5;
    localparam logic [2:0] ST_NAK   = 3'h6;

    typedef enum logic [1:0] {K_START, K_STOP, K_BYTE, K_ACK} kind_e;

    typedef struct packed {
        logic              busy;
        logic [2:0]        status;
        logic              irq;
        logic [2:0]        op;
        logic [BYTE_W-1:0] data;
        logic [BYTE_W-1:0] shift;
        logic              run;
        kind_e             kind;
        logic [CNT_W-1:0]  bitcnt;
        logic [1:0]        qtr;
        logic              ackbit;
        logic              scl_low;
        logic              sda_low;
    } eng_t;

    function automatic logic op_known(input logic [2:0] op);
        return (op == OP_START) || (op == OP_SEND) || (op == OP_STOP) || (op == OP_ACK);
    endfunction

    function automatic kind_e op_kind(input logic [2:0] op);
        case (op)
            OP_START: return K_START;
            OP_STOP:  return K_STOP;
            OP_ACK:   return K_ACK;
            default:  return K_BYTE;
        endcase
    endfunction

endpackage

// File: rtl/i2c_cmd_tick.sv
module i2c_cmd_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick = run && (cnt_q == div);
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/i2c_cmd_linemap.sv
module i2c_cmd_linemap
    import i2c_cmd_pkg::*;
(
    input  kind_e      kind,
    input  logic [1:0] qtr,
    input  logic       bit_i,
    output logic       scl_low,
    output logic       sda_low
);
    // SCL is high in quarters 1 and 2 of every clock; SDA moves in quarter 0
    // for data, and in quarter 2 for the start and stop conditions.
    always_comb begin
        scl_low = (qtr == 2'd0) || (qtr == 2'd3);
        sda_low = 1'b0;
        case (kind)
            K_START: sda_low = qtr[1];
            K_STOP:  sda_low = !qtr[1];
            K_BYTE:  sda_low = !bit_i;
            default: sda_low = 1'b0;
        endcase
        if (kind == K_STOP && qtr == 2'd3) scl_low = 1'b0;
    end
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
    import i2c_cmd_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  clk_div_i,
    input  logic [BYTE_W-1:0] tx_byte_i,
    input  logic [2:0]        op_i,
    input  logic              trig_i,
    output logic              busy_o,
    output logic [2:0]        status_o,
    output logic              irq_o,
    output logic              scl_pull_o,
    input  logic              sda_i,
    output logic              sda_pull_o
);
    localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(BYTE_W - 1);

    eng_t s_d, s_q;
    logic tick_w, map_scl, map_sda;

    i2c_cmd_tick #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (s_q.run),
        .div   (clk_div_i),
        .tick  (tick_w)
    );

    i2c_cmd_linemap u_map (
        .kind    (s_q.kind),
        .qtr     (s_q.qtr),
        .bit_i   (s_q.shift[BYTE_W-1]),
        .scl_low (map_scl),
        .sda_low (map_sda)
    );

    always_comb begin
        s_d     = s_q;
        s_d.irq = 1'b0;

        // command acceptance, or dispatch once the bit sequencer is free
        if (trig_i && !s_q.busy && op_known(op_i)) begin
            s_d.busy = 1'b1;
            s_d.op   = op_i;
            s_d.data = tx_byte_i;
        end else if (s_q.busy && !s_q.run) begin
            s_d.run    = 1'b1;
            s_d.qtr    = 2'd0;
            s_d.bitcnt = BIT_LAST;
            s_d.shift  = s_q.data;
            s_d.kind   = op_kind(s_q.op);
            if (s_q.op == OP_SEND) begin
                s_d.busy   = 1'b0;
                s_d.status = ST_SENT;
            end
        end

        // bit sequencer: four quarters per SCL clock
        if (s_q.run) begin
            s_d.scl_low = map_scl;
            s_d.sda_low = map_sda;
            if (tick_w) begin
                if (s_q.qtr == 2'd2) s_d.ackbit = sda_i;
                if (s_q.qtr != 2'd3) begin
                    s_d.qtr = s_q.qtr + 2'd1;
                end else if (s_q.kind == K_BYTE && s_q.bitcnt != '0) begin
                    s_d.qtr    = 2'd0;
                    s_d.bitcnt = s_q.bitcnt - 1'b1;
                    s_d.shift  = {s_q.shift[BYTE_W-2:0], 1'b0};
                end else begin
                    s_d.run = 1'b0;
                    case (s_q.kind)
                        K_START: begin s_d.busy = 1'b0; s_d.status = ST_START; end
                        K_STOP:  begin s_d.busy = 1'b0; s_d.status = ST_STOP;  end
                        K_ACK:   begin
                            s_d.busy   = 1'b0;
                            s_d.status = s_q.ackbit ? ST_NAK : ST_ACK;
                        end
                        default: ;
                    endcase
                end
            end
        end

        s_d.irq = s_q.busy && !s_d.busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.kind   <= K_BYTE;
            s_q.status <= ST_NONE;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o     = s_q.busy;
    assign status_o   = s_q.status;
    assign irq_o      = s_q.irq;
    assign scl_pull_o = s_q.scl_low;
    assign sda_pull_o = s_q.sda_low;

    // R9: a trigger during busy never replaces the held command
    p_busy_trig_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy && trig_i |=> s_q.op == $past(s_q.op));

    // R11: the strobe marks each falling edge of busy, and nothing else
    p_irq_on_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.busy) |-> s_q.irq);
    p_irq_only_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.irq |-> $fell(s_q.busy));

    // R3: a send on an idle sequencer releases busy one clock after acceptance
    p_send_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.busy) && s_q.op == OP_SEND && !s_q.run |=> !s_q.busy && s_q.status == ST_SENT);

    // R4: SDA is released for the whole acknowledge clock
    p_ack_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.run && $past(s_q.run) && s_q.kind == K_ACK |-> !s_q.sda_low);

    // R7: no SDA change under a high SCL while data or acknowledge clocks run
    p_sda_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.run && $past(s_q.run) && (s_q.kind == K_BYTE || s_q.kind == K_ACK)
        && !s_q.scl_low && !$past(s_q.scl_low) |-> $stable(s_q.sda_low));
endmodule

// File: tb/tb_i2c_cmd_master.sv
module tb_i2c_cmd_master;
    localparam int CLK_P = 10;
    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DIV_W-1:0] div = '0;
    logic [7:0]       txb = '0;
    logic [2:0]       op = '0;
    logic             trig = 1'b0;
    logic             busy, irq, scl_pull, sda_pull;
    logic [2:0]       status;
    logic             slave_pull = 1'b0;
    logic             scl_line, sda_line;

    int checks = 0, errors = 0;
    int nbits = 0, starts = 0, stops = 0;
    int n_start_ops = 0, n_stop_ops = 0;
    logic [7:0] rx = '0;
    time t_rise = 0, hi_width = 0;

    assign scl_line = !scl_pull;
    assign sda_line = !(sda_pull || slave_pull);

    always #(CLK_P/2) clk = !clk;

    i2c_cmd_master #(.DIV_W(DIV_W)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_div_i  (div),
        .tx_byte_i  (txb),
        .op_i       (op),
        .trig_i     (trig),
        .busy_o     (busy),
        .status_o   (status),
        .irq_o      (irq),
        .scl_pull_o (scl_pull),
        .sda_i      (sda_line),
        .sda_pull_o (sda_pull)
    );

    // bus monitor
    always @(posedge scl_line) begin
        if (nbits < 8) rx = {rx[6:0], sda_line};
        nbits++;
        t_rise = $time;
    end
    always @(negedge scl_line) hi_width = $time - t_rise;
    always @(negedge sda_line) if (scl_line === 1'b1) starts++;
    always @(posedge sda_line) if (scl_line === 1'b1) stops++;

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_ack_status(input logic pulled);
        return pulled ? 3'h5 : 3'h6;
    endfunction

    function automatic logic [7:0] addr7_byte(input logic [6:0] a, input logic rd);
        return {a, rd};
    endfunction

    function automatic logic [7:0] addr10_head(input logic [9:0] a, input logic rd);
        return {5'b11110, a[9:8], rd};
    endfunction

    task automatic issue(input logic [2:0] o, input logic [7:0] b);
        @(negedge clk);
        op = o; txb = b; trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while (busy && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check(!busy, req, busy, 0);
        if (n > 0) begin
            check(irq == 1'b1, "R11 strobe at busy fall", irq, 1);
            @(negedge clk);
            check(irq == 1'b0, "R11 strobe one cycle", irq, 0);
        end
    endtask

    task automatic do_start();
        int s0 = starts;
        issue(3'h1, 8'h00);
        n_start_ops++;
        check(busy == 1'b1, "R2 busy after start trigger", busy, 1);
        wait_idle("R5 start completes");
        check(status == 3'h1, "R5 start status", status, 1);
        check(starts == s0 + 1, "R5 one start condition", starts, s0 + 1);
        check(scl_pull == 1'b1, "R5 SCL held low after start", scl_pull, 1);
    endtask

    task automatic do_stop();
        int p0 = stops;
        issue(3'h4, 8'h00);
        n_stop_ops++;
        wait_idle("R6 stop completes");
        check(status == 3'h4, "R6 stop status", status, 4);
        check(stops == p0 + 1, "R6 one stop condition", stops, p0 + 1);
        check(scl_line && sda_line, "R6 bus released", {scl_line, sda_line}, 3);
    endtask

    task automatic xfer(input logic [7:0] b, input logic ack);
        int n = 0;
        nbits = 0;
        issue(3'h2, b);
        check(busy == 1'b1, "R2 busy after send trigger", busy, 1);
        @(negedge clk);
        check(busy == 1'b0, "R3 busy released", busy, 0);
        check(status == 3'h2, "R3 send status", status, 2);
        check(irq == 1'b1, "R11 strobe after send", irq, 1);
        while (!(nbits >= 8 && !scl_line) && n < 3000) begin
            @(negedge clk);
            n++;
        end
        slave_pull = ack;
        issue(3'h6, 8'h00);
        wait_idle("R4 ack check completes");
        slave_pull = 1'b0;
        check(status == exp_ack_status(ack), "R4 ack status", status, exp_ack_status(ack));
        check(rx == b, "R3 byte on bus MSB first", rx, b);
        check(nbits == 9, "R3 eight data clocks plus ack", nbits, 9);
        check(hi_width == time'(2 * (int'(div) + 1) * CLK_P), "R8 SCL high width",
              int'(hi_width), 2 * (int'(div) + 1) * CLK_P);
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        starts = 0; stops = 0;

        // R1 reset state
        check(busy == 0 && status == 0 && irq == 0, "R1 reset outputs", {busy, status, irq}, 0);
        check(scl_pull == 0 && sda_pull == 0, "R1 lines released", {scl_pull, sda_pull}, 0);

        // R2 unknown code ignored
        issue(3'h3, 8'h55);
        check(busy == 1'b0, "R2 unknown code ignored", busy, 0);
        @(negedge clk);
        check(busy == 1'b0 && status == 3'h0, "R2 status unchanged", status, 0);

        // 7-bit write, ACK then data
        div = 8'd1;
        do_start();
        xfer(addr7_byte(7'h2A, 1'b0), 1'b1);
        xfer(8'h81, 1'b1);
        do_stop();

        // 10-bit read: two head bytes, repeated start, head with read bit
        div = 8'd2;
        do_start();
        xfer(addr10_head(10'h2C7, 1'b0), 1'b1);
        xfer(8'hC7, 1'b1);
        do_start();
        xfer(addr10_head(10'h2C7, 1'b1), 1'b1);
        do_stop();

        // R10 queued ACK check behind a shifting byte, R9 ignored trigger while busy
        div = 8'd0;
        do_start();
        nbits = 0;
        issue(3'h2, 8'hA5);
        @(negedge clk);
        issue(3'h6, 8'h00);
        check(busy == 1'b1, "R10 queued trigger accepted", busy, 1);
        issue(3'h1, 8'h00);
        check(busy == 1'b1, "R9 busy kept", busy, 1);
        wait_idle("R10 queued op completes");
        check(status == 3'h6, "R10 NAK after queued check", status, 6);
        check(rx == 8'hA5, "R10 byte intact", rx, 8'hA5);
        check(starts == n_start_ops, "R9 no extra start", starts, n_start_ops);
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R9 ignored trigger left no work", busy, 0);
        do_stop();

        // constrained random transactions
        for (int i = 0; i < 12; i++) begin
            logic [6:0] a;
            logic       rd, ak1, ak2;
            logic [7:0] d;
            div = DIV_W'($urandom % 5);
            a   = 7'($urandom);
            rd  = 1'($urandom);
            ak1 = 1'($urandom);
            ak2 = 1'($urandom);
            d   = 8'($urandom);
            do_start();
            xfer(addr7_byte(a, rd), ak1);
            if (ak1) xfer(d, ak2);
            do_stop();
        end

        check(starts == n_start_ops, "R7 start count matches", starts, n_start_ops);
        check(stops == n_stop_ops, "R7 stop count matches", stops, n_stop_ops);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule